// File: doc/BRIEF.md
# Self-Repairing Triplicated State Register

This block holds a word of slowly changing state in three redundant copies and presents their bitwise majority. It is meant for registers that are written rarely, such as mode or configuration words. In such registers an upset in one copy could otherwise sit uncorrected for a long time, until a second upset makes it unrecoverable.

Each copy is fed through a majority vote. A per-copy minority detector sees when that copy disagrees with both of the others on any bit. That detection is ORed into the copy's load enable, so the damaged copy is rewritten from the voted state on the next clock edge even while the functional enable is idle. A sticky per-copy flag records each repair until it is cleared. Test ports flip chosen bits of one copy to emulate an upset. Each copy has an asynchronous clear and an asynchronous preset.

Top module: `tmr_state_reg`

## Requirements
- R1: When `enable` is high at a rising clock edge (and no injection targets a copy), every copy loads `dataIn`, so `dataOut` equals that value after the edge.
- R2: When `enable` is low and all three copies agree, the stored state and `dataOut` do not change across the edge.
- R3: If exactly one copy disagrees with the other two, it is rewritten from the voted state on the next rising edge, whether or not `enable` is high.
- R4: `dataOut` is the bitwise majority of the three copies, so a corruption confined to one copy never appears at `dataOut`.
- R5: `copyErr[k]` becomes 1 after any edge at which copy k was in the minority, and stays 1 until cleared.
- R6: `errClear` high at an edge clears all `copyErr` bits, except a bit whose copy is being repaired at that same edge, which is set (set wins).
- R7: `clr` high asynchronously forces every copy to all zeros and every `copyErr` bit to 0; it has priority over `pre`.
- R8: `pre` high (with `clr` low) asynchronously forces every copy to all ones and every `copyErr` bit to 0.
- R9: `injEn[k]` high at an edge XORs `injMask` into copy k, and this overrides any load of that copy at the same edge; the other copies load as usual.
- R10: When `enable` is high while copy k is in the minority, copy k loads `dataIn` with the others, and `copyErr[k]` is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| pre | input | 1 | Asynchronous preset, active high |
| enable | input | 1 | Functional load enable |
| dataIn | input | WIDTH | New state value |
| errClear | input | 1 | Clears the sticky repair flags |
| injEn | input | 3 | Per-copy upset injection strobe (test) |
| injMask | input | WIDTH | Bits flipped by an injection (test) |
| dataOut | output | WIDTH | Voted state |
| copyErr | output | 3 | Sticky per-copy repair flags |

## Verification
Some properties are checked on every cycle by the embedded assertions. These are: a functional load reaches the voted output one edge later, an idle register with agreeing copies holds its value, any minority disagreement is gone one edge after it appears, and a repaired copy always raises its flag. The bench's scenarios are needed for the rest: the timing of the asynchronous clear and preset and their priority, the repair-versus-clear race on the sticky flags, an injection that collides with a functional write, and a damaged copy that is overwritten by a fresh write. A behavioural three-copy model in the bench compares the output and the flags on every clock.

// File: rtl/tmr_state_pkg.sv
package tmr_state_pkg;
  localparam int unsigned COPIES = 3;

  typedef struct packed {
    logic [COPIES-1:0] loadCopy;  // per-copy effective load enable
    logic [COPIES-1:0] injCopy;   // per-copy upset injection
    logic              useInput;  // next value taken from dataIn, else voted state
  } ctrlStrobes_t;

  function automatic logic [COPIES-1:0] otherPair(input int unsigned k);
    logic [COPIES-1:0] r;
    r = '1;
    r[k] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/tmr_state_ctrl.sv
module tmr_state_ctrl
  import tmr_state_pkg::*;
(
  input  logic                clk,
  input  logic                clr,
  input  logic                pre,
  input  logic                enable,
  input  logic                errClear,
  input  logic [COPIES-1:0]   injEn,
  input  logic [COPIES-1:0]   minFlag,
  output ctrlStrobes_t        ctrl,
  output logic [COPIES-1:0]   copyErr
);
  logic [COPIES-1:0] stickyQ;

  always_comb begin
    ctrl.useInput = enable;
    ctrl.injCopy  = injEn;
    ctrl.loadCopy = {COPIES{enable}} | minFlag;
  end

  always_ff @(posedge clk or posedge clr or posedge pre) begin
    if (clr || pre) stickyQ <= '0;
    else            stickyQ <= (errClear ? '0 : stickyQ) | minFlag;
  end

  assign copyErr = stickyQ;

  // R5: a copy in the minority always leaves its flag raised
  a_r5_flag_on_repair: assert property (@(posedge clk) disable iff (clr || pre)
    (minFlag != '0) |=> ((copyErr & $past(minFlag)) == $past(minFlag)));

  // R6: a clear with no repair pending empties the flags
  a_r6_clear_flags: assert property (@(posedge clk) disable iff (clr || pre)
    (errClear && minFlag == '0) |=> (copyErr == '0));
endmodule

// File: rtl/tmr_state_dp.sv
module tmr_state_dp
  import tmr_state_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               pre,
  input  ctrlStrobes_t       ctrl,
  input  logic [WIDTH-1:0]   dataIn,
  input  logic [WIDTH-1:0]   injMask,
  output logic [WIDTH-1:0]   dataOut,
  output logic [COPIES-1:0]  minFlag
);
  logic [COPIES-1:0][WIDTH-1:0] copyQ;
  logic [WIDTH-1:0] voted;
  logic [WIDTH-1:0] nextVal;

  assign voted   = (copyQ[0] & copyQ[1]) | (copyQ[0] & copyQ[2]) | (copyQ[1] & copyQ[2]);
  assign nextVal = ctrl.useInput ? dataIn : voted;
  assign dataOut = voted;

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    localparam int unsigned IA = (k + 1) % COPIES;
    localparam int unsigned IB = (k + 2) % COPIES;
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk or posedge clr or posedge pre) begin
      if (clr)                     q <= '0;
      else if (pre)                q <= '1;
      else if (ctrl.injCopy[k])    q <= q ^ injMask;
      else if (ctrl.loadCopy[k])   q <= nextVal;
    end

    assign copyQ[k] = q;
    // minority detector: this copy differs from both others on some bit
    assign minFlag[k] = |((q ^ copyQ[IA]) & (q ^ copyQ[IB]));

    // R3: a lone disagreement is gone one edge later
    a_r3_repair_next_edge: assert property (@(posedge clk) disable iff (clr || pre)
      (minFlag[k] && ctrl.injCopy == '0 && $countones(minFlag) == 1) |=> !minFlag[k]);
  end

  // R1: a functional write reaches the voted output
  a_r1_load_visible: assert property (@(posedge clk) disable iff (clr || pre)
    (ctrl.useInput && ctrl.injCopy == '0) |=> (dataOut == $past(dataIn)));

  // R2: idle, agreeing copies hold their value
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (clr || pre)
    (!ctrl.useInput && minFlag == '0 && ctrl.injCopy == '0) |=> $stable(dataOut));

  // R4: a single injected copy does not disturb the voted output
  a_r4_vote_masks: assert property (@(posedge clk) disable iff (clr || pre)
    (!ctrl.useInput && minFlag == '0 && $onehot0(ctrl.injCopy)) |=> $stable(dataOut));
endmodule

// File: rtl/tmr_state_reg.sv
module tmr_state_reg
  import tmr_state_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              pre,
  input  logic              enable,
  input  logic [WIDTH-1:0]  dataIn,
  input  logic              errClear,
  input  logic [2:0]        injEn,
  input  logic [WIDTH-1:0]  injMask,
  output logic [WIDTH-1:0]  dataOut,
  output logic [2:0]        copyErr
);
  ctrlStrobes_t      ctrl;
  logic [COPIES-1:0] minFlag;

  tmr_state_ctrl ctrl_i (
    .clk(clk), .clr(clr), .pre(pre), .enable(enable), .errClear(errClear),
    .injEn(injEn), .minFlag(minFlag), .ctrl(ctrl), .copyErr(copyErr)
  );

  tmr_state_dp #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .clr(clr), .pre(pre), .ctrl(ctrl), .dataIn(dataIn),
    .injMask(injMask), .dataOut(dataOut), .minFlag(minFlag)
  );
endmodule

// File: tb/tmr_state_reg_tb_top.sv
module tmr_state_reg_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clr = 1'b0, pre = 1'b0, enable = 1'b0, errClear = 1'b0;
  logic [W-1:0] dataIn = '0, injMask = '0;
  logic [2:0] injEn = '0;
  logic [W-1:0] dataOut;
  logic [2:0] copyErr;

  int nCmp = 0, nBad = 0, cycles = 0;
  string curReq = "R7";

  // behavioural model
  logic [W-1:0] mq [3];
  logic [2:0] mErr = '0;
  logic [W-1:0] mv;
  logic [2:0] mFlag;

  always #2 clk = ~clk;

  tmr_state_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .clr(clr), .pre(pre), .enable(enable), .dataIn(dataIn),
    .errClear(errClear), .injEn(injEn), .injMask(injMask),
    .dataOut(dataOut), .copyErr(copyErr)
  );

  function automatic logic [W-1:0] maj(input logic [W-1:0] a, b, c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
    return r;
  endfunction

  initial for (int k = 0; k < 3; k++) mq[k] = '0;

  always @(posedge clk or posedge clr or posedge pre) begin
    if (clr) begin
      for (int k = 0; k < 3; k++) mq[k] = '0;
      mErr = '0;
    end else if (pre) begin
      for (int k = 0; k < 3; k++) mq[k] = '1;
      mErr = '0;
    end else begin
      mv = maj(mq[0], mq[1], mq[2]);
      for (int k = 0; k < 3; k++) mFlag[k] = (mq[k] != mv);
      for (int k = 0; k < 3; k++) begin
        if (injEn[k]) mq[k] = mq[k] ^ injMask;
        else if (enable || mFlag[k]) mq[k] = enable ? dataIn : mv;
      end
      mErr = (errClear ? 3'b000 : mErr) | mFlag;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(dataOut == maj(mq[0], mq[1], mq[2]), curReq, 32'(dataOut), 32'(maj(mq[0], mq[1], mq[2])));
    chk(copyErr == mErr, curReq, 32'(copyErr), 32'(mErr));
    if (cycles > 5000) begin
      nBad++; nCmp++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  task automatic step(input bit en, input logic [W-1:0] d, input logic [2:0] inj,
                      input logic [W-1:0] m, input bit ec);
    @(negedge clk);
    #1;
    enable = en; dataIn = d; injEn = inj; injMask = m; errClear = ec;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 3'b000, '0, 1'b0);
  endtask

  initial begin
    // R7: asynchronous clear, seen without a clock edge
    #1 clr = 1'b1;
    #0.5;
    chk(dataOut == 8'h00 && copyErr == 3'b000, "R7 reset", 32'(dataOut), 32'h0);
    #2 clr = 1'b0;
    idle(2);

    curReq = "R1";
    step(1'b1, 8'hA5, 3'b000, '0, 1'b0);
    step(1'b1, 8'h3C, 3'b000, '0, 1'b0);
    step(1'b1, 8'hA5, 3'b000, '0, 1'b0);
    @(negedge clk); #1.5;
    chk(dataOut == 8'hA5, "R1 load", 32'(dataOut), 32'hA5);

    curReq = "R2";
    idle(3);
    #1.5 chk(dataOut == 8'hA5, "R2 hold", 32'(dataOut), 32'hA5);

    // R4/R3/R5: corrupt copy 0 while idle
    curReq = "R4";
    step(1'b0, 8'h00, 3'b001, 8'h0F, 1'b0);
    step(1'b0, 8'h00, 3'b000, 8'h00, 1'b0);
    chk(dataOut == 8'hA5, "R4 masked", 32'(dataOut), 32'hA5);
    curReq = "R3";
    idle(1);
    chk(copyErr == 3'b001, "R5 sticky set", 32'(copyErr), 32'h1);
    idle(3);
    chk(copyErr == 3'b001, "R5 sticky held", 32'(copyErr), 32'h1);

    curReq = "R6";
    step(1'b0, 8'h00, 3'b000, 8'h00, 1'b1);
    idle(1);
    chk(copyErr == 3'b000, "R6 clear", 32'(copyErr), 32'h0);

    // R9: injection into copy 2 collides with a functional write
    curReq = "R9";
    step(1'b1, 8'h5A, 3'b100, 8'hF0, 1'b0);
    idle(1);
    chk(dataOut == 8'h5A, "R9 write wins on others", 32'(dataOut), 32'h5A);
    idle(2);
    chk(copyErr == 3'b100, "R3 copy2 repaired", 32'(copyErr), 32'h4);

    // R6: clear races a repair on copy 1 -> set wins for copy 1
    curReq = "R6";
    step(1'b0, 8'h00, 3'b010, 8'h81, 1'b0);
    step(1'b0, 8'h00, 3'b000, 8'h00, 1'b1);
    idle(1);
    chk(copyErr == 3'b010, "R6 set wins", 32'(copyErr), 32'h2);

    // R10: copy 0 in minority while a new value is written
    curReq = "R10";
    step(1'b0, 8'h00, 3'b000, 8'h00, 1'b1);
    step(1'b0, 8'h00, 3'b001, 8'h18, 1'b0);
    step(1'b1, 8'hC3, 3'b000, 8'h00, 1'b0);
    idle(1);
    chk(dataOut == 8'hC3 && copyErr == 3'b001, "R10 write plus flag", 32'({copyErr, dataOut}), 32'h1C3);
    idle(2);

    // R8: asynchronous preset
    curReq = "R8";
    @(negedge clk); #1 pre = 1'b1;
    #0.5 chk(dataOut == 8'hFF && copyErr == 3'b000, "R8 preset", 32'({copyErr, dataOut}), 32'hFF);
    @(negedge clk); #1 clr = 1'b1;
    #0.5 chk(dataOut == 8'h00, "R7 clear over preset", 32'(dataOut), 32'h0);
    @(negedge clk); #1 pre = 1'b0;
    @(negedge clk); #1 clr = 1'b0;
    curReq = "R1";
    step(1'b1, 8'h96, 3'b000, '0, 1'b0);
    idle(2);
    chk(dataOut == 8'h96, "R1 after resets", 32'(dataOut), 32'h96);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule